// File: doc/BRIEF.md
# Indexed Nibble Subtract Sequencer

This block carries out a family of subtract-with-borrow instructions whose target is a 4-bit cell of data memory. The cell is found through one of two 16-bit index registers. The value in the B input and the carry flag are both taken away from the stored nibble. If the difference goes below zero, the result is corrected back into a radix between 1 and 16, which the instruction itself selects. The corrected nibble is then written back to the same cell. The carry and zero flags are updated, and some forms then step the chosen index register forward by one.

A one-shot 8-bit page override can be armed before an instruction. When it is armed, the forms that do not step the index take their address from a fixed page instead of from the index: the low page for X and the top page for Y. Every subtract instruction disarms the override, including the ones that ignore it. The index registers, the carry flag and the override are loaded through simple load strobes. These strobes stand in for the writes made by other instructions. Opcodes outside the family are flagged as unsupported and have no effect.

Top module: `rsub_seq`

## Requirements
- R1: An opcode belongs to the family when bits [12:6] equal 1110001b. Bit 5 selects Y (1) or X (0) as the index. Bit 4 selects the post-increment form. Bits [3:0] give the radix, where code 0 means radix 16.
- R2: An accepted instruction takes two cycles. In the issue cycle, `mem_rd` is high and the address is driven. In the following cycle, `busy` and `mem_wr` are high and the same address is driven. An `issue` that arrives while `busy` is high is ignored.
- R3: The written nibble is memory − B − carry. If that difference is negative, the radix is added to it and the carry becomes 1. Otherwise the carry becomes 0.
- R4: The zero flag is 1 exactly when the written nibble is 0. Carry and zero change only at the end of the write cycle.
- R5: A post-increment form adds 1 to the selected index register after the write, wrapping from FFFFh to 0000h. The other index register and the flags are not affected by the step.
- R6: A non-incrementing form with the override armed uses address 00h:imm for X or FFh:imm for Y. It leaves both index registers unchanged.
- R7: A post-increment form with the override armed ignores the override and uses the index register.
- R8: The override-armed bit is 0 after any subtract instruction completes.
- R9: For an opcode outside the family, `unsupported` is high in the issue cycle and neither memory strobe rises. The index registers, flags and override are left as they were.
- R10: After reset, both index registers are 0, carry, zero and override-armed are 0, and the block is idle.
- R11: The load strobes for X, Y, carry and override take effect at the next clock edge while the block is idle. They are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Present `opcode` for execution |
| opcode | input | 13 | Instruction word |
| b_reg | input | 4 | B register value (subtrahend) |
| busy | output | 1 | Write cycle in progress |
| unsupported | output | 1 | Issued opcode is outside the family |
| mem_addr | output | 16 | Data memory address |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_rdata | input | 4 | Read data |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| x_load | input | 1 | Load X from `idx_wdata` |
| y_load | input | 1 | Load Y from `idx_wdata` |
| idx_wdata | input | 16 | Index load value |
| c_load | input | 1 | Load carry from `c_wdata` |
| c_wdata | input | 1 | Carry load value |
| ext_load | input | 1 | Arm override with `ext_imm` |
| ext_imm | input | 8 | Override page offset |
| x_q | output | 16 | X index register |
| y_q | output | 16 | Y index register |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| ext_valid | output | 1 | Override armed |

## Verification
A wrong latched address or decode field shows up on `mem_addr` in the write cycle, which is one clock after the read. A wrong correction or carry shows up on `mem_wdata` in that same cycle. Stale flags, a missed index step or an override left armed become visible on `flag_c`, `flag_z`, `x_q`, `y_q` or `ext_valid` at the first idle cycle after the write. So every internal fault is exposed within two clocks of `issue`.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WB   = 1'b1
   } rsub_state_e;

   typedef struct packed {
      logic sel_y;
      logic post_inc;
   } rsub_op_t;
endpackage

// File: rtl/rsub_decode.sv
module rsub_decode
   import rsub_pkg::*;
#(
   parameter int OPC_W = 13,
   parameter int RDX_W = 4,
   localparam int FAM_W = OPC_W - RDX_W - 2,
   parameter logic [FAM_W-1:0] FAMILY = 7'b1110001
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             hit,
   output rsub_op_t         op,
   output logic [RDX_W-1:0] radix
);
   if (FAM_W < 1) begin : g_bad_width
      $error("rsub_decode: opcode too narrow for radix field");
   end

   always_comb begin
      hit         = (opcode[OPC_W-1:RDX_W+2] == FAMILY);
      op.sel_y    = opcode[RDX_W+1];
      op.post_inc = opcode[RDX_W];
      radix       = opcode[RDX_W-1:0];
   end
endmodule

// File: rtl/rsub_radix_alu.sv
module rsub_radix_alu #(
   parameter int W = 4
) (
   input  logic [W-1:0] minuend,
   input  logic [W-1:0] subtrahend,
   input  logic         borrow_in,
   input  logic [W-1:0] radix,
   output logic [W-1:0] result,
   output logic         borrow_out,
   output logic         zero
);
   if (W < 1) begin : g_bad_width
      $error("rsub_radix_alu: width must be positive");
   end

   logic [W:0] raw;

   always_comb begin
      raw        = {1'b0, minuend} - {1'b0, subtrahend} - {{W{1'b0}}, borrow_in};
      borrow_out = raw[W];
      // a zero radix code stands for 2**W, which adds nothing modulo 2**W
      result     = raw[W-1:0] + (borrow_out ? radix : '0);
      zero       = (result == '0);
   end
endmodule

// File: rtl/rsub_addr_gen.sv
module rsub_addr_gen #(
   parameter int ADDR_W    = 16,
   parameter int EXT_W     = 8,
   parameter bit PREFIX_EN = 1'b1,
   localparam int PAGE_W   = ADDR_W - EXT_W
) (
   input  logic [ADDR_W-1:0] idx_x,
   input  logic [ADDR_W-1:0] idx_y,
   input  logic              sel_y,
   input  logic              post_inc,
   input  logic              ext_valid,
   input  logic [EXT_W-1:0]  ext_imm,
   output logic [ADDR_W-1:0] addr
);
   if (PAGE_W < 1) begin : g_bad_width
      $error("rsub_addr_gen: address must be wider than override offset");
   end

   logic [ADDR_W-1:0] idx_addr;
   assign idx_addr = sel_y ? idx_y : idx_x;

   if (PREFIX_EN) begin : g_prefix
      logic [ADDR_W-1:0] page_addr;
      assign page_addr = {{PAGE_W{sel_y}}, ext_imm};
      assign addr      = (ext_valid && !post_inc) ? page_addr : idx_addr;
   end else begin : g_no_prefix
      logic unused_ok;
      assign unused_ok = ^{ext_valid, ext_imm, post_inc};
      assign addr      = idx_addr;
   end
endmodule

// File: rtl/rsub_seq.sv
module rsub_seq
   import rsub_pkg::*;
#(
   parameter int OPC_W  = 13,
   parameter int DATA_W = 4,
   parameter int ADDR_W = 16,
   parameter int EXT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] b_reg,
   output logic              busy,
   output logic              unsupported,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              x_load,
   input  logic              y_load,
   input  logic [ADDR_W-1:0] idx_wdata,
   input  logic              c_load,
   input  logic              c_wdata,
   input  logic              ext_load,
   input  logic [EXT_W-1:0]  ext_imm,
   output logic [ADDR_W-1:0] x_q,
   output logic [ADDR_W-1:0] y_q,
   output logic              flag_c,
   output logic              flag_z,
   output logic              ext_valid
);
   localparam int RDX_EFF_W = DATA_W + 1;

   if (DATA_W != 4) begin : g_bad_data
      $error("rsub_seq: radix field is a nibble");
   end

   rsub_state_e       st_q;
   rsub_op_t          dec_op, op_q;
   logic              dec_hit;
   logic [DATA_W-1:0] dec_radix, radix_q;
   logic [ADDR_W-1:0] addr_cur, addr_q;
   logic [EXT_W-1:0]  ext_q;
   logic              go;
   logic              alu_borrow, alu_zero;
   logic [DATA_W-1:0] alu_res;

   rsub_decode #(.OPC_W(OPC_W), .RDX_W(DATA_W)) u_dec (
      .opcode (opcode),
      .hit    (dec_hit),
      .op     (dec_op),
      .radix  (dec_radix)
   );

   rsub_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .PREFIX_EN(1'b1)) u_agen (
      .idx_x     (x_q),
      .idx_y     (y_q),
      .sel_y     (dec_op.sel_y),
      .post_inc  (dec_op.post_inc),
      .ext_valid (ext_valid),
      .ext_imm   (ext_q),
      .addr      (addr_cur)
   );

   rsub_radix_alu #(.W(DATA_W)) u_alu (
      .minuend    (mem_rdata),
      .subtrahend (b_reg),
      .borrow_in  (flag_c),
      .radix      (radix_q),
      .result     (alu_res),
      .borrow_out (alu_borrow),
      .zero       (alu_zero)
   );

   assign busy        = (st_q == ST_WB);
   assign go          = issue && !busy && dec_hit;
   assign unsupported = issue && !busy && !dec_hit;
   assign mem_rd      = go;
   assign mem_wr      = busy;
   assign mem_addr    = busy ? addr_q : addr_cur;
   assign mem_wdata   = alu_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         x_q       <= '0;
         y_q       <= '0;
         flag_c    <= 1'b0;
         flag_z    <= 1'b0;
         ext_valid <= 1'b0;
         ext_q     <= '0;
         addr_q    <= '0;
         op_q      <= '0;
         radix_q   <= '0;
      end else if (!busy) begin
         if (x_load)   x_q <= idx_wdata;
         if (y_load)   y_q <= idx_wdata;
         if (c_load)   flag_c <= c_wdata;
         if (ext_load) begin
            ext_valid <= 1'b1;
            ext_q     <= ext_imm;
         end
         if (go) begin
            st_q    <= ST_WB;
            addr_q  <= addr_cur;
            op_q    <= dec_op;
            radix_q <= dec_radix;
         end
      end else begin
         st_q      <= ST_IDLE;
         flag_c    <= alu_borrow;
         flag_z    <= alu_zero;
         ext_valid <= 1'b0;
         if (op_q.post_inc) begin
            if (op_q.sel_y) y_q <= y_q + 1'b1;
            else            x_q <= x_q + 1'b1;
         end
      end
   end

   // ---------------- assertions ----------------
   logic [RDX_EFF_W-1:0] rdx_eff;
   assign rdx_eff = (radix_q == '0) ? RDX_EFF_W'(1 << DATA_W) : {1'b0, radix_q};

   assert_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> mem_wr);
   assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);
   assert_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_addr == $past(mem_addr));
   assert_in_radix_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && ({1'b0, mem_rdata} < rdx_eff) && ({1'b0, b_reg} < rdx_eff))
      |-> ({1'b0, mem_wdata} < rdx_eff));
   assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> flag_z == ($past(mem_wdata) == '0));
   assert_z_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr |=> $stable(flag_z));
   assert_x_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && op_q.post_inc && !op_q.sel_y) |=> x_q == ADDR_W'($past(x_q) + 1'b1));
   assert_y_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && op_q.post_inc && op_q.sel_y) |=> y_q == ADDR_W'($past(y_q) + 1'b1));
   assert_prefix_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !ext_valid);
   assert_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/rsub_seq_tb.sv
module rsub_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [12:0] opcode = '0;
   logic [3:0]  b_reg = '0;
   logic        busy, unsupported, mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [3:0]  mem_rdata, mem_wdata;
   logic        x_load = 1'b0, y_load = 1'b0, c_load = 1'b0, c_wdata = 1'b0, ext_load = 1'b0;
   logic [15:0] idx_wdata = '0;
   logic [7:0]  ext_imm = '0;
   logic [15:0] x_q, y_q;
   logic        flag_c, flag_z, ext_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rsub_seq dut_i (
      .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .b_reg(b_reg),
      .busy(busy), .unsupported(unsupported), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .x_load(x_load), .y_load(y_load), .idx_wdata(idx_wdata), .c_load(c_load),
      .c_wdata(c_wdata), .ext_load(ext_load), .ext_imm(ext_imm), .x_q(x_q), .y_q(y_q),
      .flag_c(flag_c), .flag_z(flag_z), .ext_valid(ext_valid)
   );

   logic [3:0] mem [256];
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [15:0] opc;
      logic [15:0] xv;
      logic [15:0] yv;
      logic [3:0]  bv;
      logic        cin;
      logic        pv;
      logic [7:0]  pimm;
      logic [3:0]  mv;
      logic [15:0] ea;
      logic [3:0]  ew;
      logic        ec;
      logic        ez;
      logic [15:0] ex;
      logic [15:0] ey;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{16'h1C4A, 16'h0010, 16'h0020, 4'd5,  1'b0, 1'b0, 8'h00, 4'd3,  16'h0010, 4'd8, 1'b1, 1'b0, 16'h0010, 16'h0020},
      '{16'h1C60, 16'h0011, 16'h0022, 4'd3,  1'b1, 1'b0, 8'h00, 4'd9,  16'h0022, 4'd5, 1'b0, 1'b0, 16'h0011, 16'h0022},
      '{16'h1C5A, 16'h0030, 16'h0040, 4'd4,  1'b0, 1'b0, 8'h00, 4'd4,  16'h0030, 4'd0, 1'b0, 1'b1, 16'h0031, 16'h0040},
      '{16'h1C7A, 16'h0005, 16'hFFFF, 4'd0,  1'b1, 1'b0, 8'h00, 4'd0,  16'hFFFF, 4'd9, 1'b1, 1'b0, 16'h0005, 16'h0000},
      '{16'h1C48, 16'h1234, 16'h5678, 4'd7,  1'b0, 1'b1, 8'h3C, 4'd2,  16'h003C, 4'd3, 1'b1, 1'b0, 16'h1234, 16'h5678},
      '{16'h1C6C, 16'h0200, 16'h0100, 4'd2,  1'b1, 1'b1, 8'hA5, 4'd11, 16'hFFA5, 4'd8, 1'b0, 1'b0, 16'h0200, 16'h0100},
      '{16'h1C5F, 16'h0044, 16'h0055, 4'd14, 1'b1, 1'b1, 8'h77, 4'd0,  16'h0044, 4'd0, 1'b1, 1'b1, 16'h0045, 16'h0055},
      '{16'h1C70, 16'h0001, 16'h00AB, 4'd15, 1'b0, 1'b1, 8'h12, 4'd15, 16'h00AB, 4'd0, 1'b0, 1'b1, 16'h0001, 16'h00AC},
      '{16'h1C61, 16'h0000, 16'h0003, 4'd0,  1'b0, 1'b0, 8'h00, 4'd0,  16'h0003, 4'd0, 1'b0, 1'b1, 16'h0000, 16'h0003},
      '{16'h1C42, 16'h00C0, 16'h0000, 4'd1,  1'b1, 1'b0, 8'h00, 4'd1,  16'h00C0, 4'd1, 1'b1, 1'b0, 16'h00C0, 16'h0000}
   };

   task automatic load_regs(input logic [15:0] xv, input logic [15:0] yv, input logic cv);
      @(negedge clk); x_load = 1'b1; idx_wdata = xv;
      @(negedge clk); x_load = 1'b0; y_load = 1'b1; idx_wdata = yv;
      @(negedge clk); y_load = 1'b0; c_load = 1'b1; c_wdata = cv;
      @(negedge clk); c_load = 1'b0;
   endtask

   task automatic arm(input logic [7:0] imm);
      @(negedge clk); ext_load = 1'b1; ext_imm = imm;
      @(negedge clk); ext_load = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 x", x_q, 0);
      chk("R10 y", y_q, 0);
      chk("R10 flags", {flag_c, flag_z, ext_valid}, 0);
      chk("R10 idle", {busy, mem_wr, mem_rd}, 0);

      for (int i = 0; i < NV; i++) begin
         load_regs(VECS[i].xv, VECS[i].yv, VECS[i].cin);
         chk("R11 carry load", flag_c, VECS[i].cin);
         if (VECS[i].pv) begin
            arm(VECS[i].pimm);
            chk("R11 override armed", ext_valid, 1);
         end
         mem[VECS[i].ea[7:0]] = VECS[i].mv;
         b_reg = VECS[i].bv;
         @(negedge clk);
         issue = 1'b1; opcode = VECS[i].opc[12:0];
         #1;
         chk("R1 R6 R7 read addr", mem_addr, VECS[i].ea);
         chk("R2 read strobe", {mem_rd, mem_wr, unsupported}, 3'b100);
         @(negedge clk);
         issue = 1'b0;
         #1;
         chk("R2 write cycle", {busy, mem_wr, mem_rd}, 3'b110);
         chk("R2 write addr", mem_addr, VECS[i].ea);
         chk("R3 result", mem_wdata, VECS[i].ew);
         chk("R4 carry held", flag_c, VECS[i].cin);
         @(negedge clk);
         chk("R3 carry", flag_c, VECS[i].ec);
         chk("R4 zero", flag_z, VECS[i].ez);
         chk("R5 R6 x", x_q, VECS[i].ex);
         chk("R5 R6 y", y_q, VECS[i].ey);
         chk("R8 override cleared", ext_valid, 0);
         chk("R2 memory written", mem[VECS[i].ea[7:0]], VECS[i].ew);
      end

      // R9: unsupported opcodes leave state alone
      arm(8'h55);
      @(negedge clk); c_load = 1'b1; c_wdata = 1'b1;
      @(negedge clk); c_load = 1'b0;
      issue = 1'b1; opcode = 13'h1C80;
      #1;
      chk("R9 flagged", unsupported, 1);
      chk("R9 no access", {mem_rd, mem_wr}, 0);
      @(negedge clk);
      opcode = 13'h1C3F;
      #1;
      chk("R9 flagged low", unsupported, 1);
      @(negedge clk);
      issue = 1'b0;
      chk("R9 state kept", {ext_valid, flag_c, flag_z, busy}, 4'b1100);
      chk("R9 x kept", x_q, 16'h00C0);

      // R2/R11: issue and load ignored while busy; R6 override with X
      mem[8'h55] = 4'd7;
      b_reg = 4'd2;
      issue = 1'b1; opcode = 13'h1C40;
      #1;
      chk("R6 override addr", mem_addr, 16'h0055);
      @(negedge clk);
      x_load = 1'b1; idx_wdata = 16'h1111;
      #1;
      chk("R2 busy ignores issue", {busy, mem_rd, unsupported}, 3'b100);
      chk("R3 result carry in", mem_wdata, 4'd4);
      @(negedge clk);
      issue = 1'b0; x_load = 1'b0;
      chk("R11 load ignored busy", x_q, 16'h00C0);
      chk("R3 no borrow", {flag_c, flag_z, ext_valid}, 3'b000);
      @(negedge clk);
      chk("R2 no second op", {busy, mem_wr}, 2'b00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule